// File: doc/BRIEF.md
# Disk Sector Header Search Engine

This block sits behind a disk read latch and hunts for one requested sector in the raw byte stream. A latch sample counts only when its most significant bit is set. All other samples are skipped, so the latch may be polled every cycle. After a start pulse, the engine looks for the three-byte address-field prologue. It then decodes the four payload values that follow, each carried as a pair of 4-and-4 encoded bytes: volume, then track, then sector, then checksum.

When the decoded sector and track both equal the values captured at start, the engine switches to data-search mode and watches for the data-field prologue. Any address field seen in either mode is decoded and judged again. The engine reports each decoded address field with a verdict pulse. It raises `data_found_o` when the data prologue follows a matching address field, and then goes idle. The data payload, checksum verification and epilogue bytes are left to downstream logic.

Top module: `sector_hdr_finder`

## Requirements
- R1: After reset, `busy_o`, `data_mode_o`, `fields_vld_o`, `addr_match_o`, `addr_miss_o` and `data_found_o` are 0, and all four decoded field outputs are 0x00.
- R2: A latch sample whose bit 7 is 0 changes no state and produces no strobe.
- R3: The byte sequence 0xD5, 0xAA, 0x96 starts an address field. One cycle after the latch presents the eighth payload byte, `fields_vld_o` pulses for exactly one cycle, together with exactly one of `addr_match_o` or `addr_miss_o`, and the four field outputs hold the decoded values.
- R4: Each field value v is carried as a first byte {1,v7,1,v5,1,v3,1,v1} and a second byte {1,v6,1,v4,1,v2,1,v0}. It is recovered as ((first << 1) | 1) & second. The payload order is volume, track, sector, checksum.
- R5: When the byte after 0xD5 is not 0xAA, that byte is tested again as a possible new 0xD5. So 0xD5 0xD5 0xAA 0x96 still starts an address field.
- R6: In address-search mode, 0xD5 0xAA followed by any byte other than 0x96 restarts the search without a strobe. This includes 0xAD.
- R7: A decoded field set whose sector and track both equal the latched request gives `addr_match_o` and sets `data_mode_o`. Any other set gives `addr_miss_o` and clears `data_mode_o`.
- R8: In data-search mode, 0xD5 0xAA 0xAD pulses `data_found_o` for one cycle. The engine then clears `busy_o` and `data_mode_o`.
- R9: In data-search mode, 0xD5 0xAA followed by a byte other than 0xAD or 0x96 clears `data_mode_o` and restarts the address search.
- R10: In data-search mode, 0xD5 0xAA 0x96 begins a new address field, which is decoded and judged as in R3 and R7.
- R11: The requested track and sector are captured on the cycle `start_i` is high. Later changes on `req_track_i` and `req_sector_i` have no effect until the next start.
- R12: Before the first start, and after `data_found_o`, the engine is idle. `busy_o` is 0, and prologue or payload bytes give no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new search and capture the request |
| req_track_i | input | 8 | Requested track |
| req_sector_i | input | 8 | Requested sector |
| latch_i | input | 8 | Read latch sample, valid when bit 7 is 1 |
| busy_o | output | 1 | Search in progress |
| data_mode_o | output | 1 | Searching for the data prologue |
| fields_vld_o | output | 1 | Address field fully decoded (pulse) |
| addr_match_o | output | 1 | Decoded track and sector match the request (pulse) |
| addr_miss_o | output | 1 | Decoded track or sector differs (pulse) |
| data_found_o | output | 1 | Data prologue found after a match (pulse) |
| volume_o | output | 8 | Last decoded volume |
| track_o | output | 8 | Last decoded track |
| sector_o | output | 8 | Last decoded sector |
| checksum_o | output | 8 | Last decoded checksum |

## Verification
The stream is tried in several forms:
- Clean prologues with idle gaps.
- A doubled 0xD5 and a stray byte after 0xD5, which separate a re-test from a discard.
- Samples with bit 7 clear that mimic prologue and payload values, which show the valid-bit filter in action.
- A data prologue sent in address mode and again after a match, which isolates the mode dependence.
- A non-data third byte in data mode, followed by a data prologue, which shows that the mode was really dropped.

Field values 0x00, 0xFF and mixed patterns are sent through the design. The 4-and-4 code is also round-tripped for all 256 values.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_FIELDS = 4;
  // field order on the medium is behaviour
  localparam int IDX_VOL = 0;
  localparam int IDX_TRK = 1;
  localparam int IDX_SEC = 2;
  localparam int IDX_CHK = 3;

  localparam logic [BYTE_W-1:0] MARK_LEAD = 8'hD5;
  localparam logic [BYTE_W-1:0] MARK_SYNC = 8'hAA;
  localparam logic [BYTE_W-1:0] MARK_ADDR = 8'h96;
  localparam logic [BYTE_W-1:0] MARK_DATA = 8'hAD;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_P1,
    ST_P2,
    ST_P3,
    ST_ODD,
    ST_EVEN
  } st_e;
endpackage

// File: rtl/shf_dec44.sv
module shf_dec44 #(
  parameter int W = 8
) (
  input  logic [W-1:0] odd_i,
  input  logic [W-1:0] even_i,
  output logic [W-1:0] val_o
);
  // odd byte shifted up puts its data bits on the odd positions
  assign val_o = {odd_i[W-2:0], 1'b1} & even_i;
endmodule

// File: rtl/shf_field_regs.sv
module shf_field_regs #(
  parameter int W  = 8,
  parameter int NF = 4,
  localparam int IW = $clog2(NF)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IW-1:0]        idx_i,
  input  logic [W-1:0]         d_i,
  output logic [NF-1:0][W-1:0] q_o
);
  logic [W-1:0] fld_q [NF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NF; k++) fld_q[k] <= '0;
    end else if (we_i) begin
      for (int k = 0; k < NF; k++)
        if (idx_i == IW'(k)) fld_q[k] <= d_i;
    end
  end

  for (genvar g = 0; g < NF; g++) begin : g_out
    assign q_o[g] = fld_q[g];
  end
endmodule

// File: rtl/shf_ctrl.sv
module shf_ctrl
  import shf_pkg::*;
#(
  parameter int W  = 8,
  parameter int NF = 4,
  localparam int IW = $clog2(NF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  byte_i,
  input  logic          match_i,
  output logic          field_we_o,
  output logic [IW-1:0] field_idx_o,
  output logic [W-1:0]  odd_o,
  output logic          busy_o,
  output logic          data_mode_o,
  output logic          fields_vld_o,
  output logic          match_o,
  output logic          miss_o,
  output logic          found_o
);
  st_e           st_q, st_d;
  logic          mode_q, mode_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [W-1:0]  odd_q, odd_d;
  logic          fvld_q, fvld_d, match_q, match_d, miss_q, miss_d, found_q, found_d;
  logic          acc;
  logic          we;

  assign acc = byte_i[W-1];

  always_comb begin
    st_d    = st_q;
    mode_d  = mode_q;
    idx_d   = idx_q;
    odd_d   = odd_q;
    fvld_d  = 1'b0;
    match_d = 1'b0;
    miss_d  = 1'b0;
    found_d = 1'b0;
    we      = 1'b0;
    if (start_i) begin
      st_d   = ST_P1;
      mode_d = 1'b0;
    end else if (acc) begin
      case (st_q)
        ST_P1: if (byte_i == W'(MARK_LEAD)) st_d = ST_P2;
        ST_P2: begin
          if (byte_i == W'(MARK_SYNC))      st_d = ST_P3;
          else if (byte_i == W'(MARK_LEAD)) st_d = ST_P2;  // re-test as lead
          else                              st_d = ST_P1;
        end
        ST_P3: begin
          if (byte_i == W'(MARK_ADDR)) begin
            st_d  = ST_ODD;
            idx_d = '0;
          end else if (mode_q && byte_i == W'(MARK_DATA)) begin
            found_d = 1'b1;
            st_d    = ST_IDLE;
            mode_d  = 1'b0;
          end else begin
            st_d   = ST_P1;
            mode_d = 1'b0;
          end
        end
        ST_ODD: begin
          odd_d = byte_i;
          st_d  = ST_EVEN;
        end
        ST_EVEN: begin
          we = 1'b1;
          if (idx_q == IW'(NF - 1)) begin
            fvld_d  = 1'b1;
            match_d = match_i;
            miss_d  = !match_i;
            mode_d  = match_i;
            st_d    = ST_P1;
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = ST_ODD;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mode_q  <= 1'b0;
      idx_q   <= '0;
      odd_q   <= '0;
      fvld_q  <= 1'b0;
      match_q <= 1'b0;
      miss_q  <= 1'b0;
      found_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      mode_q  <= mode_d;
      idx_q   <= idx_d;
      odd_q   <= odd_d;
      fvld_q  <= fvld_d;
      match_q <= match_d;
      miss_q  <= miss_d;
      found_q <= found_d;
    end
  end

  assign field_we_o   = we;
  assign field_idx_o  = idx_q;
  assign odd_o        = odd_q;
  assign busy_o       = (st_q != ST_IDLE);
  assign data_mode_o  = mode_q;
  assign fields_vld_o = fvld_q;
  assign match_o      = match_q;
  assign miss_o       = miss_q;
  assign found_o      = found_q;
endmodule

// File: rtl/sector_hdr_finder.sv
module sector_hdr_finder
  import shf_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] req_track_i,
  input  logic [W-1:0] req_sector_i,
  input  logic [W-1:0] latch_i,
  output logic         busy_o,
  output logic         data_mode_o,
  output logic         fields_vld_o,
  output logic         addr_match_o,
  output logic         addr_miss_o,
  output logic         data_found_o,
  output logic [W-1:0] volume_o,
  output logic [W-1:0] track_o,
  output logic [W-1:0] sector_o,
  output logic [W-1:0] checksum_o
);
  localparam int NF = NUM_FIELDS;
  localparam int IW = $clog2(NF);

  logic [W-1:0]         req_trk_q, req_sec_q;
  logic [W-1:0]         odd_byte, dec_val;
  logic                 fld_we;
  logic [IW-1:0]        fld_idx;
  logic [NF-1:0][W-1:0] flds;
  logic                 sec_ok, trk_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_trk_q <= '0;
      req_sec_q <= '0;
    end else if (start_i) begin
      req_trk_q <= req_track_i;
      req_sec_q <= req_sector_i;
    end
  end

  // verdict is taken while the checksum pair lands; track and sector already stored
  assign sec_ok = (flds[IDX_SEC] == req_sec_q);
  assign trk_ok = (flds[IDX_TRK] == req_trk_q);

  shf_ctrl #(.W(W), .NF(NF)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .byte_i       (latch_i),
    .match_i      (sec_ok && trk_ok),
    .field_we_o   (fld_we),
    .field_idx_o  (fld_idx),
    .odd_o        (odd_byte),
    .busy_o       (busy_o),
    .data_mode_o  (data_mode_o),
    .fields_vld_o (fields_vld_o),
    .match_o      (addr_match_o),
    .miss_o       (addr_miss_o),
    .found_o      (data_found_o)
  );

  shf_dec44 #(.W(W)) i_dec (
    .odd_i  (odd_byte),
    .even_i (latch_i),
    .val_o  (dec_val)
  );

  shf_field_regs #(.W(W), .NF(NF)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (fld_we),
    .idx_i  (fld_idx),
    .d_i    (dec_val),
    .q_o    (flds)
  );

  assign volume_o   = flds[IDX_VOL];
  assign track_o    = flds[IDX_TRK];
  assign sector_o   = flds[IDX_SEC];
  assign checksum_o = flds[IDX_CHK];
endmodule

// File: rtl/shf_checker.sv
module shf_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic byte_msb_i,
  input logic busy_o,
  input logic data_mode_o,
  input logic fields_vld_o,
  input logic addr_match_o,
  input logic addr_miss_o,
  input logic data_found_o
);
  a_r8_found_needs_data_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_found_o |-> $past(data_mode_o));

  a_r8_found_ends_search: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_found_o |-> (!busy_o && !data_mode_o));

  a_r7_match_enters_data_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_match_o |-> data_mode_o);

  a_r7_verdict_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_match_o && addr_miss_o));

  a_r3_verdict_with_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fields_vld_o |-> $onehot({addr_match_o, addr_miss_o}));

  a_r2_invalid_byte_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !byte_msb_i && !start_i) |=>
      ($stable(data_mode_o) && busy_o && !fields_vld_o && !data_found_o));

  a_r12_idle_stays_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> (!busy_o && !fields_vld_o && !data_found_o));
endmodule

bind sector_hdr_finder shf_checker i_shf_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .byte_msb_i   (latch_i[7]),
  .busy_o       (busy_o),
  .data_mode_o  (data_mode_o),
  .fields_vld_o (fields_vld_o),
  .addr_match_o (addr_match_o),
  .addr_miss_o  (addr_miss_o),
  .data_found_o (data_found_o)
);

// File: tb/test_sector_hdr_finder.sv
module test_sector_hdr_finder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] req_trk = '0, req_sec = '0, latch = '0;
  logic       busy, dmode, fvld, amatch, amiss, dfound;
  logic [7:0] vol, trk, sec, chk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // kind: 0 match, 1 miss, 2 data found
  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] v, t, s, c;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  sector_hdr_finder i_sector_hdr_finder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .req_track_i(req_trk), .req_sector_i(req_sec), .latch_i(latch),
    .busy_o(busy), .data_mode_o(dmode), .fields_vld_o(fvld),
    .addr_match_o(amatch), .addr_miss_o(amiss), .data_found_o(dfound),
    .volume_o(vol), .track_o(trk), .sector_o(sec), .checksum_o(chk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] enc_hi(input logic [7:0] v);
    return (v >> 1) | 8'hAA;
  endfunction
  function automatic logic [7:0] enc_lo(input logic [7:0] v);
    return v | 8'hAA;
  endfunction

  task automatic put(input logic [7:0] b);
    @(negedge clk); latch = b;
    @(negedge clk); latch = 8'h00;
  endtask

  task automatic prologue(input logic [7:0] third);
    put(8'hD5); put(8'hAA); put(third);
  endtask

  task automatic payload(input logic [7:0] v, t, s, c);
    put(enc_hi(v)); put(enc_lo(v));
    put(enc_hi(t)); put(enc_lo(t));
    put(enc_hi(s)); put(enc_lo(s));
    put(enc_hi(c)); put(enc_lo(c));
  endtask

  task automatic addr_field(input logic [7:0] v, t, s, c, input bit hit);
    exp_t e;
    e.kind = hit ? 2'd0 : 2'd1;
    e.v = v; e.t = t; e.s = s; e.c = c;
    exp_q.push_back(e);
    prologue(8'h96);
    payload(v, t, s, c);
  endtask

  task automatic start_req(input logic [7:0] t, s);
    @(negedge clk); start = 1'b1; req_trk = t; req_sec = s;
    @(negedge clk); start = 1'b0; req_trk = ~t; req_sec = ~s;  // R11: later changes ignored
  endtask

  // monitor: pops the scoreboard on every strobe
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (fvld || dfound)) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R12 unexpected strobe", {fvld, dfound}, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.kind == 2'd2) begin
            check(dfound && !fvld, "R8 data found", {fvld, dfound}, 1);
          end else begin
            check(fvld && (amatch == (e.kind == 2'd0)) && (amiss == (e.kind == 2'd1)),
                  "R7 verdict", {amatch, amiss}, (e.kind == 2'd0) ? 2 : 1);
            check({vol, trk, sec, chk} == {e.v, e.t, e.s, e.c}, "R3 R4 fields",
                  {vol, trk, sec, chk}, {e.v, e.t, e.s, e.c});
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R4: round trip of the code for every value
    for (int v = 0; v < 256; v++) begin
      logic [7:0] hi, lo, back;
      hi = enc_hi(8'(v)); lo = enc_lo(8'(v));
      back = ({hi[6:0], 1'b1}) & lo;
      check(back == 8'(v) && hi[7] && lo[7] && hi != 8'hD5 && lo != 8'hD5,
            "R4 round trip", back, v);
    end

    repeat (3) @(negedge clk);
    check({busy, dmode, fvld, amatch, amiss, dfound} == 6'b0, "R1 reset strobes",
          {busy, dmode, fvld, amatch, amiss, dfound}, 0);
    check({vol, trk, sec, chk} == 32'h0, "R1 reset fields", {vol, trk, sec, chk}, 0);
    rst_n = 1'b1;

    // R12: bytes before any start give nothing
    prologue(8'h96); payload(8'h11, 8'h05, 8'h03, 8'h17);
    prologue(8'hAD);
    check(!busy, "R12 idle before start", busy, 0);

    start_req(8'h05, 8'h03);
    check(busy && !dmode, "R11 start busy", {busy, dmode}, 2);

    // R2: bit-7-clear lookalikes
    put(8'h55); put(8'h2A); put(8'h16);
    put(8'h55); put(8'h2A); put(8'h16);
    put(8'h7F); put(8'h2A); put(8'h7F);
    check(busy && !dmode, "R2 invalid bytes ignored", {busy, dmode}, 2);

    // R6: data prologue in address mode
    prologue(8'hAD);
    check(busy && !dmode, "R6 data prologue in address mode", {busy, dmode}, 2);

    // R5: doubled lead byte, wrong track
    put(8'hD5);
    addr_field(8'hFE, 8'h07, 8'h03, 8'hFA, 1'b0);
    check(!dmode, "R7 miss keeps address mode", dmode, 0);

    // stray byte after lead, wrong sector
    put(8'hD5); put(8'hB7);
    addr_field(8'h00, 8'h05, 8'h09, 8'h0C, 1'b0);

    // R7 match, with noise between bytes
    put(8'h40);
    addr_field(8'hFE, 8'h05, 8'h03, 8'hF8, 1'b1);
    check(dmode && busy, "R7 match enters data mode", {busy, dmode}, 3);

    // R10: address field in data mode re-judged
    addr_field(8'hFF, 8'h05, 8'h03, 8'hFF, 1'b1);
    check(dmode, "R10 still data mode", dmode, 1);

    // R9: other third byte drops data mode
    prologue(8'hEB);
    check(!dmode && busy, "R9 mode dropped", {busy, dmode}, 2);
    prologue(8'hAD);
    check(!dmode, "R9 no found after drop", dmode, 0);

    // R8: match then data prologue
    addr_field(8'hA5, 8'h05, 8'h03, 8'h5A, 1'b1);
    exp_q.push_back('{kind: 2'd2, v: 8'h0, t: 8'h0, s: 8'h0, c: 8'h0});
    prologue(8'hAD);
    check(!busy && !dmode, "R8 idle after found", {busy, dmode}, 0);

    // R12: idle after found
    addr_field(8'h01, 8'h05, 8'h03, 8'h06, 1'b1);
    void'(exp_q.pop_back());
    prologue(8'hAD);
    check(!busy, "R12 idle after found", busy, 0);

    // R11: new request with extreme values, data mode miss returns to address mode
    start_req(8'h22, 8'h0F);
    addr_field(8'h00, 8'h22, 8'h0F, 8'h00, 1'b1);
    addr_field(8'h00, 8'h23, 8'h0F, 8'h00, 1'b0);
    check(!dmode, "R7 data mode miss clears mode", dmode, 0);
    addr_field(8'hFF, 8'h22, 8'h0F, 8'hFF, 1'b1);
    exp_q.push_back('{kind: 2'd2, v: 8'h0, t: 8'h0, s: 8'h0, c: 8'h0});
    put(8'hD5); put(8'hD5); put(8'hAA); put(8'hAD);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 all expected strobes seen", exp_q.size(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule